// File: doc/BRIEF.md
# Processor Exception Dispatch Unit

This block is the trap-entry and trap-return controller of a small 32-bit embedded processor core. When the pipeline reports a synchronous fault, the unit chooses the handler address and stores the address of the faulting instruction in the proper save register. It latches the cause code and, for address-related faults, the offending data address. It then sets the exception-mode flag in the status word and sends the fetch stage a one-cycle redirect strobe carrying the handler address.

The unit also executes the two return operations. The ordinary return clears the exception-mode flag and resumes at the level-1 saved address. The double-fault return leaves the status word alone and resumes at the double-fault saved address. A fault raised while the exception-mode flag is already set is a double fault. It goes to its own handler, and its return address lands in a separate save register when the parameter `HAS_DBL_PC` is 1. The status word can also be loaded directly through a write port.

Control is a three-state machine:
- `S_BOOT` holds for one cycle after reset and issues the reset redirect (`S_BOOT -> S_FLUSH`).
- `S_RUN` accepts work. A taken trap or return moves it `S_RUN -> S_FLUSH`. A status write or no request keeps it `S_RUN -> S_RUN`.
- `S_FLUSH` is the cycle in which the strobe is high. Requests there are discarded (`S_FLUSH -> S_RUN`).

Top module: `exc_dispatch`

## Requirements
- R1: While reset is held, the status word is 0x0000001f and the redirect strobe is low. On the first clock after reset is released, the strobe pulses with target 0x5fff8000.
- R2: A fault taken with status bit 4 (exception mode) clear stores `instr_pc` in the level-1 save register. It redirects to 0x5fff863c when status bit 5 (user mode) is 1, and to 0x5fff861c when bit 5 is 0.
- R3: Every taken fault writes its 6-bit cause into the cause register and sets status bit 4. No other status bit changes.
- R4: A fault taken with status bit 4 already set redirects to 0x5fff865c. With `HAS_DBL_PC`=1 it stores `instr_pc` in the double save register and leaves the level-1 save register unchanged. With `HAS_DBL_PC`=0 it stores `instr_pc` in the level-1 save register.
- R5: A taken fault with `exc_addr_valid`=1 loads `exc_addr` into the bad-address register. With `exc_addr_valid`=0, that register keeps its value.
- R6: An ordinary return at ring 0 clears status bit 4, leaves all other status bits unchanged, and redirects to the level-1 save register value.
- R7: A double-fault return at ring 0 redirects to the double save register value, or to the level-1 save register value when `HAS_DBL_PC`=0. The status word stays unchanged.
- R8: A return requested with `ring` not 0 is not performed. Instead a fault with cause 8 is taken at `instr_pc`, following R2/R4. The bad-address register stays unchanged.
- R9: Priority in one cycle is fault request first, then ordinary return, then double-fault return, then status write.
- R10: The redirect strobe lasts exactly one cycle, and the save and status registers update on the same edge that raises it. Requests presented while the strobe is high are discarded.
- R11: A status write with no fault or return pending loads `sts_wdata` into the status word and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_pc | input | 32 | Address of the faulting or returning instruction |
| exc_req | input | 1 | Synchronous fault request |
| exc_cause | input | 6 | Cause code of the fault |
| exc_addr_valid | input | 1 | Fault carries a data address |
| exc_addr | input | 32 | Offending data address |
| rfe_req | input | 1 | Ordinary return request |
| rfde_req | input | 1 | Double-fault return request |
| ring | input | 2 | Current privilege ring, 0 = most privileged |
| sts_we | input | 1 | Status word write enable |
| sts_wdata | input | 32 | Status word write data |
| redirect_valid | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc | output | 32 | Redirect target |
| status_q | output | 32 | Status word |
| ret_pc_q | output | 32 | Level-1 save register |
| dbl_pc_q | output | 32 | Double save register (0 when absent) |
| cause_q | output | 6 | Cause register |
| bad_addr_q | output | 32 | Bad-address register |

## Verification
The bench runs two copies of the block, with and without the double save register, and aims at a fault taken while exception mode is already set. A design that ignored the mode flag would send that fault to the kernel handler and overwrite the level-1 return address. The bench also drives returns at a non-zero ring, which a careless design would simply execute, and a fault together with a return in the same cycle, where a wrong priority would resume instead of trapping. Requests held through the strobe cycle check that a second trap is not taken from an already-squashed instruction, and a fault without a data address checks that the bad-address register is not clobbered.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int STS_EXCM_BIT = 4;
    localparam int STS_UM_BIT   = 5;
    localparam logic [31:0] STS_RESET_VAL = 32'h0000_001f;
    localparam int PRIV_CAUSE_CODE = 8;

    typedef enum logic [1:0] {
        S_BOOT  = 2'd0,
        S_RUN   = 2'd1,
        S_FLUSH = 2'd2
    } ctl_state_e;

    typedef enum logic [2:0] {
        ACT_NONE = 3'd0,
        ACT_BOOT = 3'd1,
        ACT_TRAP = 3'd2,
        ACT_RFE  = 3'd3,
        ACT_RFDE = 3'd4,
        ACT_WSTS = 3'd5
    } act_e;
endpackage

// File: rtl/exc_vec_sel.sv
module exc_vec_sel #(
    parameter int          XLEN       = 32,
    parameter bit          HAS_DBL_PC = 1'b1,
    parameter logic [31:0] KERNEL_VEC = 32'h5fff_861c,
    parameter logic [31:0] USER_VEC   = 32'h5fff_863c,
    parameter logic [31:0] DOUBLE_VEC = 32'h5fff_865c
) (
    input  logic            excm,
    input  logic            user_mode,
    output logic            to_dbl_reg,
    output logic [XLEN-1:0] vector
);
    always_comb begin
        to_dbl_reg = excm && HAS_DBL_PC;
        if (excm)
            vector = DOUBLE_VEC[XLEN-1:0];
        else if (user_mode)
            vector = USER_VEC[XLEN-1:0];
        else
            vector = KERNEL_VEC[XLEN-1:0];
    end
endmodule

// File: rtl/exc_ctrl_fsm.sv
module exc_ctrl_fsm
    import exc_pkg::*;
#(
    parameter int CAUSE_W = 6,
    parameter int RING_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exc_req,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic               rfe_req,
    input  logic               rfde_req,
    input  logic [RING_W-1:0]  ring,
    input  logic               sts_we,
    output act_e               act,
    output logic [CAUSE_W-1:0] trap_cause,
    output logic               in_run
);
    localparam logic [CAUSE_W-1:0] PRIV_CAUSE = CAUSE_W'(PRIV_CAUSE_CODE);

    ctl_state_e state_q, state_d;
    logic       ret_any, priv_fault;

    assign ret_any    = rfe_req || rfde_req;
    assign priv_fault = ret_any && (ring != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        act        = ACT_NONE;
        trap_cause = exc_cause;
        in_run     = 1'b0;
        unique case (state_q)
            S_BOOT: begin
                act     = ACT_BOOT;
                state_d = S_FLUSH;
            end
            S_RUN: begin
                in_run = 1'b1;
                if (exc_req) begin
                    act     = ACT_TRAP;
                    state_d = S_FLUSH;
                end else if (priv_fault) begin
                    act        = ACT_TRAP;
                    trap_cause = PRIV_CAUSE;
                    state_d    = S_FLUSH;
                end else if (rfe_req) begin
                    act     = ACT_RFE;
                    state_d = S_FLUSH;
                end else if (rfde_req) begin
                    act     = ACT_RFDE;
                    state_d = S_FLUSH;
                end else if (sts_we) begin
                    act = ACT_WSTS;
                end
            end
            S_FLUSH: begin
                state_d = S_RUN;
            end
            default: begin
                state_d = S_BOOT;
            end
        endcase
    end
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
    import exc_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          CAUSE_W    = 6,
    parameter int          RING_W     = 2,
    parameter bit          HAS_DBL_PC = 1'b1,
    parameter logic [31:0] RESET_VEC  = 32'h5fff_8000,
    parameter logic [31:0] KERNEL_VEC = 32'h5fff_861c,
    parameter logic [31:0] USER_VEC   = 32'h5fff_863c,
    parameter logic [31:0] DOUBLE_VEC = 32'h5fff_865c
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [XLEN-1:0]    instr_pc,
    input  logic               exc_req,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic               exc_addr_valid,
    input  logic [XLEN-1:0]    exc_addr,
    input  logic               rfe_req,
    input  logic               rfde_req,
    input  logic [RING_W-1:0]  ring,
    input  logic               sts_we,
    input  logic [XLEN-1:0]    sts_wdata,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc,
    output logic [XLEN-1:0]    status_q,
    output logic [XLEN-1:0]    ret_pc_q,
    output logic [XLEN-1:0]    dbl_pc_q,
    output logic [CAUSE_W-1:0] cause_q,
    output logic [XLEN-1:0]    bad_addr_q
);
    act_e               act;
    logic [CAUSE_W-1:0] trap_cause;
    logic               in_run;
    logic               to_dbl_reg;
    logic [XLEN-1:0]    trap_vec;
    logic [XLEN-1:0]    rfde_target;

    exc_ctrl_fsm #(.CAUSE_W(CAUSE_W), .RING_W(RING_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .exc_req    (exc_req),
        .exc_cause  (exc_cause),
        .rfe_req    (rfe_req),
        .rfde_req   (rfde_req),
        .ring       (ring),
        .sts_we     (sts_we),
        .act        (act),
        .trap_cause (trap_cause),
        .in_run     (in_run)
    );

    exc_vec_sel #(
        .XLEN(XLEN), .HAS_DBL_PC(HAS_DBL_PC),
        .KERNEL_VEC(KERNEL_VEC), .USER_VEC(USER_VEC), .DOUBLE_VEC(DOUBLE_VEC)
    ) u_vec (
        .excm       (status_q[STS_EXCM_BIT]),
        .user_mode  (status_q[STS_UM_BIT]),
        .to_dbl_reg (to_dbl_reg),
        .vector     (trap_vec)
    );

    generate
        if (HAS_DBL_PC) begin : g_dbl
            always_ff @(posedge clk) begin
                if (!rst_n)
                    dbl_pc_q <= '0;
                else if (act == ACT_TRAP && to_dbl_reg)
                    dbl_pc_q <= instr_pc;
            end
            assign rfde_target = dbl_pc_q;
        end else begin : g_no_dbl
            assign dbl_pc_q    = '0;
            assign rfde_target = ret_pc_q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q       <= STS_RESET_VAL[XLEN-1:0];
            ret_pc_q       <= '0;
            cause_q        <= '0;
            bad_addr_q     <= '0;
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
        end else begin
            redirect_valid <= 1'b0;
            unique case (act)
                ACT_BOOT: begin
                    redirect_valid <= 1'b1;
                    redirect_pc    <= RESET_VEC[XLEN-1:0];
                end
                ACT_TRAP: begin
                    redirect_valid <= 1'b1;
                    redirect_pc    <= trap_vec;
                    if (!to_dbl_reg)
                        ret_pc_q <= instr_pc;
                    cause_q <= trap_cause;
                    status_q[STS_EXCM_BIT] <= 1'b1;
                    if (exc_req && exc_addr_valid)
                        bad_addr_q <= exc_addr;
                end
                ACT_RFE: begin
                    redirect_valid <= 1'b1;
                    redirect_pc    <= ret_pc_q;
                    status_q[STS_EXCM_BIT] <= 1'b0;
                end
                ACT_RFDE: begin
                    redirect_valid <= 1'b1;
                    redirect_pc    <= rfde_target;
                end
                ACT_WSTS: begin
                    status_q <= sts_wdata;
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/exc_dispatch_chk.sv
module exc_dispatch_chk
    import exc_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          CAUSE_W    = 6,
    parameter int          RING_W     = 2,
    parameter logic [31:0] DOUBLE_VEC = 32'h5fff_865c
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_run,
    input logic               exc_req,
    input logic [CAUSE_W-1:0] exc_cause,
    input logic               rfe_req,
    input logic               rfde_req,
    input logic [RING_W-1:0]  ring,
    input logic [XLEN-1:0]    instr_pc,
    input logic               redirect_valid,
    input logic [XLEN-1:0]    redirect_pc,
    input logic [XLEN-1:0]    status_q,
    input logic [XLEN-1:0]    ret_pc_q,
    input logic [CAUSE_W-1:0] cause_q
);
    localparam logic [CAUSE_W-1:0] PRIV_CAUSE = CAUSE_W'(PRIV_CAUSE_CODE);

    assert_kernel_save_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_run && exc_req && !status_q[STS_EXCM_BIT] |=> ret_pc_q == $past(instr_pc));

    assert_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_run && exc_req |=> redirect_valid && status_q[STS_EXCM_BIT] && cause_q == $past(exc_cause));

    assert_double_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_run && exc_req && status_q[STS_EXCM_BIT] |=> redirect_pc == DOUBLE_VEC[XLEN-1:0]);

    assert_rfe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_run && !exc_req && rfe_req && ring == '0
        |=> !status_q[STS_EXCM_BIT] && redirect_pc == $past(ret_pc_q));

    assert_rfde_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_run && !exc_req && !rfe_req && rfde_req && ring == '0 |=> $stable(status_q));

    assert_priv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_run && !exc_req && (rfe_req || rfde_req) && ring != '0
        |=> cause_q == PRIV_CAUSE && status_q[STS_EXCM_BIT]);

    assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid);
endmodule

bind exc_dispatch exc_dispatch_chk #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .RING_W(RING_W), .DOUBLE_VEC(DOUBLE_VEC)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_run         (in_run),
    .exc_req        (exc_req),
    .exc_cause      (exc_cause),
    .rfe_req        (rfe_req),
    .rfde_req       (rfde_req),
    .ring           (ring),
    .instr_pc       (instr_pc),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .status_q       (status_q),
    .ret_pc_q       (ret_pc_q),
    .cause_q        (cause_q)
);

// File: tb/test_exc_dispatch.sv
module test_exc_dispatch;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] V_RESET  = 32'h5fff_8000;
    localparam logic [31:0] V_KERNEL = 32'h5fff_861c;
    localparam logic [31:0] V_USER   = 32'h5fff_863c;
    localparam logic [31:0] V_DOUBLE = 32'h5fff_865c;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_pc = '0;
    logic        exc_req = 1'b0;
    logic [5:0]  exc_cause = '0;
    logic        exc_addr_valid = 1'b0;
    logic [31:0] exc_addr = '0;
    logic        rfe_req = 1'b0;
    logic        rfde_req = 1'b0;
    logic [1:0]  ring = '0;
    logic        sts_we = 1'b0;
    logic [31:0] sts_wdata = '0;

    logic        rv    [2];
    logic [31:0] rpc   [2];
    logic [31:0] sts   [2];
    logic [31:0] retpc [2];
    logic [31:0] dblpc [2];
    logic [5:0]  cause [2];
    logic [31:0] baddr [2];

    logic [31:0] m_sts [2];
    logic [31:0] m_ret [2];
    logic [31:0] m_dbl [2];
    logic [5:0]  m_cause [2];
    logic [31:0] m_addr [2];
    logic        m_rv [2];
    logic [31:0] m_rpc [2];

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_dispatch #(.HAS_DBL_PC(1'b1)) i_exc_dispatch (
        .clk(clk), .rst_n(rst_n), .instr_pc(instr_pc), .exc_req(exc_req),
        .exc_cause(exc_cause), .exc_addr_valid(exc_addr_valid), .exc_addr(exc_addr),
        .rfe_req(rfe_req), .rfde_req(rfde_req), .ring(ring), .sts_we(sts_we),
        .sts_wdata(sts_wdata), .redirect_valid(rv[0]), .redirect_pc(rpc[0]),
        .status_q(sts[0]), .ret_pc_q(retpc[0]), .dbl_pc_q(dblpc[0]),
        .cause_q(cause[0]), .bad_addr_q(baddr[0])
    );

    exc_dispatch #(.HAS_DBL_PC(1'b0)) i_exc_dispatch_nd (
        .clk(clk), .rst_n(rst_n), .instr_pc(instr_pc), .exc_req(exc_req),
        .exc_cause(exc_cause), .exc_addr_valid(exc_addr_valid), .exc_addr(exc_addr),
        .rfe_req(rfe_req), .rfde_req(rfde_req), .ring(ring), .sts_we(sts_we),
        .sts_wdata(sts_wdata), .redirect_valid(rv[1]), .redirect_pc(rpc[1]),
        .status_q(sts[1]), .ret_pc_q(retpc[1]), .dbl_pc_q(dblpc[1]),
        .cause_q(cause[1]), .bad_addr_q(baddr[1])
    );

    task automatic chk(string req, string what, int k, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s cfg%0d: got %h expected %h", req, what, k, got, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int k = 0; k < 2; k++) begin
            chk(req, "redirect_valid", k, 32'(rv[k]), 32'(m_rv[k]));
            if (m_rv[k]) chk(req, "redirect_pc", k, rpc[k], m_rpc[k]);
            chk(req, "status", k, sts[k], m_sts[k]);
            chk(req, "ret_pc", k, retpc[k], m_ret[k]);
            chk(req, "dbl_pc", k, dblpc[k], m_dbl[k]);
            chk("R3", "cause", k, 32'(cause[k]), 32'(m_cause[k]));
            chk("R5", "bad_addr", k, baddr[k], m_addr[k]);
        end
    endtask

    function automatic string model_step();
        string tag = "idle";
        for (int k = 0; k < 2; k++) begin
            bit has_dbl = (k == 0);
            bit trap = 1'b0;
            logic [5:0] tc = exc_cause;
            m_rv[k] = 1'b0;
            if (exc_req) begin
                trap = 1'b1;
                tag = (rfe_req || rfde_req) ? "R9" : (m_sts[k][4] ? "R4" : "R2");
            end else if ((rfe_req || rfde_req) && ring != 2'd0) begin
                trap = 1'b1; tc = 6'd8; tag = "R8";
            end else if (rfe_req) begin
                m_rv[k] = 1'b1; m_rpc[k] = m_ret[k];
                m_sts[k][4] = 1'b0; tag = "R6";
            end else if (rfde_req) begin
                m_rv[k] = 1'b1; m_rpc[k] = has_dbl ? m_dbl[k] : m_ret[k]; tag = "R7";
            end else if (sts_we) begin
                m_sts[k] = sts_wdata; tag = "R11";
            end
            if (trap) begin
                m_rv[k] = 1'b1;
                if (m_sts[k][4]) begin
                    m_rpc[k] = V_DOUBLE;
                    if (has_dbl) m_dbl[k] = instr_pc;
                    else         m_ret[k] = instr_pc;
                end else begin
                    m_rpc[k] = m_sts[k][5] ? V_USER : V_KERNEL;
                    m_ret[k] = instr_pc;
                end
                m_cause[k] = tc;
                m_sts[k][4] = 1'b1;
                if (exc_req && exc_addr_valid) m_addr[k] = exc_addr;
            end
        end
        return tag;
    endfunction

    task automatic clear_in();
        exc_req = 1'b0; rfe_req = 1'b0; rfde_req = 1'b0; sts_we = 1'b0;
        exc_addr_valid = 1'b0; ring = 2'd0;
    endtask

    task automatic do_op(bit ex, logic [5:0] c, bit av, logic [31:0] a, bit r1, bit r2,
                         logic [1:0] rg, bit we, logic [31:0] wd, logic [31:0] pc);
        string tag;
        @(negedge clk);
        exc_req = ex; exc_cause = c; exc_addr_valid = av; exc_addr = a;
        rfe_req = r1; rfde_req = r2; ring = rg; sts_we = we; sts_wdata = wd; instr_pc = pc;
        tag = model_step();
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
        clear_in();
    endtask

    task automatic wr_status(logic [31:0] v);
        do_op(0, 0, 0, 0, 0, 0, 0, 1, v, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int k = 0; k < 2; k++) begin
            m_sts[k] = 32'h1f; m_ret[k] = '0; m_dbl[k] = '0;
            m_cause[k] = '0; m_addr[k] = '0; m_rv[k] = 1'b0; m_rpc[k] = '0;
        end
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk("R1", "boot strobe", k, 32'(rv[k]), 32'd1);
            chk("R1", "boot target", k, rpc[k], V_RESET);
        end
        @(negedge clk);
        for (int k = 0; k < 2; k++) chk("R10", "boot strobe end", k, 32'(rv[k]), 32'd0);

        // Status after reset has exception mode set: first fault is a double fault (R4)
        do_op(1, 6'd0, 0, 0, 0, 0, 0, 0, 0, 32'h0000_1000);
        // Clear exception mode, kernel vector (R2)
        do_op(0, 0, 0, 0, 1, 0, 0, 0, 0, 32'h0000_2000);
        do_op(1, 6'd1, 0, 0, 0, 0, 0, 0, 0, 32'h0000_3000);
        // Second fault in handler: double fault (R4), then double return (R7)
        do_op(1, 6'd9, 1, 32'hdead_beef, 0, 0, 0, 0, 0, 32'h0000_3100);
        do_op(0, 0, 0, 0, 0, 1, 0, 0, 0, 32'h0000_3200);
        // User vector (R2) with address recorded (R5)
        wr_status(32'h0000_0020);
        do_op(1, 6'd3, 1, 32'h1234_5678, 0, 0, 0, 0, 0, 32'h0000_4000);
        // Address not valid keeps old value (R5)
        do_op(0, 0, 0, 0, 1, 0, 0, 0, 0, 32'h0000_4100);
        do_op(1, 6'd6, 0, 32'hffff_0000, 0, 0, 0, 0, 0, 32'h0000_4200);
        // Privileged return at ring 1 (R8), ring 3 double return (R8)
        do_op(0, 0, 0, 0, 1, 0, 2'd0, 0, 0, 32'h0000_4300);
        do_op(0, 0, 0, 0, 1, 0, 2'd1, 0, 0, 32'h0000_5000);
        do_op(0, 0, 0, 0, 0, 1, 2'd3, 0, 0, 32'h0000_5100);
        // Fault and return together: fault wins (R9)
        wr_status(32'h0000_0000);
        do_op(1, 6'd4, 0, 0, 1, 1, 0, 0, 0, 32'h0000_6000);
        // Status write ignored when a return is pending (R9)
        do_op(0, 0, 0, 0, 1, 0, 0, 1, 32'hffff_ffff, 32'h0000_6100);
        // Requests held through the strobe cycle are discarded (R10)
        @(negedge clk);
        exc_req = 1'b1; exc_cause = 6'd2; instr_pc = 32'h0000_7000;
        void'(model_step());
        @(posedge clk);
        @(negedge clk);
        check_all("R10");
        instr_pc = 32'h0000_7100; exc_cause = 6'd5;
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 2; k++) m_rv[k] = 1'b0;
        check_all("R10");
        clear_in();

        for (int i = 0; i < 500; i++) begin
            int op = $urandom_range(0, 9);
            logic [31:0] pc = $urandom() & 32'hffff_fffc;
            logic [1:0] rg = ($urandom_range(0, 4) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
            unique case (op)
                0, 1, 2: do_op(1, 6'($urandom_range(0, 9)), 1'($urandom_range(0, 1)),
                               $urandom(), 0, 0, 0, 0, 0, pc);
                3, 4:    do_op(0, 0, 0, 0, 1, 0, rg, 0, 0, pc);
                5:       do_op(0, 0, 0, 0, 0, 1, rg, 0, 0, pc);
                6:       do_op(1, 6'($urandom_range(0, 9)), 1, $urandom(),
                               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), rg, 0, 0, pc);
                default: wr_status($urandom() & 32'hffff_ffef | (32'($urandom_range(0, 1)) << 4));
            endcase
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule